// File: doc/BRIEF.md
# Memory-Mapped Signed Divider

This block is a word-addressed register file around an iterative signed divider. Software first stores a divisor. It then starts a division with one of two writes. A write to the narrow dividend word divides that single word by the divisor. A write to the low dividend word divides the double-width value formed by the high dividend word and the written word. No separate command is needed.

Each division takes one quotient bit per clock. A `busy` output is high while the division runs. When it completes, the quotient and the remainder are each written into two result words, so software can read either copy. All arithmetic is two's complement and truncates toward zero. Two cases are settled by fixed rules instead of by the divider: a zero divisor clears the results at once, and a double-width quotient that does not fit in one word saturates to the signed extreme.

Top module: `sdiv_mmio`

Word indices on the address ports: 0 divisor, 1 narrow dividend / narrow quotient, 4 wide dividend high / remainder, 5 wide dividend low / wide quotient, 6 remainder copy, 7 quotient copy. Indices 2 and 3 are unmapped.

## Requirements
- R1: Writes to mapped indices 0, 1, 4, 5, 6 and 7 store the written word, and reads return it. Indices 2 and 3 read as zero and ignore writes.
- R2: When the divisor is nonzero, a write to index 1 starts a narrow divide of the written word by the divisor. On completion the quotient goes to indices 1 and 7 and the remainder to indices 4 and 6.
- R3: When the divisor is nonzero, a write to index 5 starts a wide divide of the double word {index 4, written word}. On completion the quotient goes to indices 5 and 7 and the remainder to indices 4 and 6.
- R4: Quotients round toward zero. A nonzero remainder has the sign of the dividend, and its magnitude is below that of the divisor.
- R5: A start write while the divisor is zero clears indices 4, 5, 6 and 7 on that clock edge and leaves `busy` low. It abandons any division in progress, whose results are never written. Index 1 keeps the written word.
- R6: A wide quotient above the largest signed word becomes 0x7F..F. One below the smallest signed word becomes 0x80..0. The remainder is written exactly as in R4.
- R7: A narrow divide of the most negative word by -1 yields the most negative word as quotient (the low W bits of the true quotient) and zero as remainder.
- R8: `busy` rises on the edge of a start write with a nonzero divisor and stays high for exactly 2W+1 clock cycles. While it is high, reads return the contents held before the start.
- R9: A start write while `busy` is high abandons the running division and begins the new one. `busy` then lasts 2W+1 cycles from the new start, and only the new results are written.
- R10: After reset every register reads zero and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one word |
| bus_waddr | input | 3 | Word index of the write |
| bus_wdata | input | W | Write data |
| bus_raddr | input | 3 | Word index of the read |
| bus_rdata | output | W | Read data, combinational from `bus_raddr` |
| busy | output | 1 | High while a division is in progress |

## Verification
The bench builds the divider with W = 4. At that width every narrow dividend and divisor pair, 256 pairs, can be swept. So can every wide dividend against every divisor, 4096 combinations. The sweep reaches every saturation boundary on both signs, the most-negative-by-minus-one case, every zero-divisor start, and every mix of operand signs. Expected quotients, remainders and saturation values come from integer arithmetic in the bench. Two directed sequences cover a restart during a running division and a zero-divisor start during a running division.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  localparam int REG_COUNT    = 8;
  localparam int IDX_DIVISOR  = 0;
  localparam int IDX_NARROW   = 1;
  localparam int IDX_WIDE_HI  = 4;
  localparam int IDX_WIDE_LO  = 5;
  localparam int IDX_REM_MIR  = 6;
  localparam int IDX_QUO_MIR  = 7;
  localparam logic [REG_COUNT-1:0] MAPPED_MASK = 8'b1111_0011;

  typedef enum logic [1:0] {
    START_NONE,
    START_NARROW,
    START_WIDE,
    START_ZERO
  } start_e;
endpackage

// File: rtl/sdiv_wr_decode.sv
module sdiv_wr_decode
  import sdiv_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic                 divisor_nz,
  output logic [REG_COUNT-1:0] reg_wen,
  output start_e               start_kind
);
  genvar gi;
  generate
    for (gi = 0; gi < REG_COUNT; gi++) begin : g_wen
      assign reg_wen[gi] = we && (waddr == AW'(gi)) && MAPPED_MASK[gi];
    end
  endgenerate

  always_comb begin
    start_kind = START_NONE;
    if (reg_wen[IDX_NARROW])       start_kind = divisor_nz ? START_NARROW : START_ZERO;
    else if (reg_wen[IDX_WIDE_LO]) start_kind = divisor_nz ? START_WIDE   : START_ZERO;
  end
endmodule

// File: rtl/sdiv_core.sv
module sdiv_core #(
  parameter int W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            kill,
  input  logic [2*W-1:0]  dvd_mag,
  input  logic [W-1:0]    dsr_mag,
  output logic [2*W-1:0]  q_mag,
  output logic [W-1:0]    r_mag,
  output logic            done,
  output logic            active
);
  localparam int DW = 2 * W;
  localparam int CW = $clog2(DW + 1);

  logic [W-1:0]    rem_q, dsr_q;
  logic [DW-1:0]   dq_q;
  logic [CW-1:0]   cnt_q;
  logic            done_q;
  logic [W+DW-1:0] step_res;

  // one restoring step: shift in the next dividend bit, subtract if it fits
  function automatic logic [W+DW-1:0] div_step(input logic [W-1:0] rem,
                                               input logic [DW-1:0] dq,
                                               input logic [W-1:0] dsr);
    logic [W:0] trial;
    logic [W:0] diff;
    trial = {rem, dq[DW-1]};
    diff  = trial - {1'b0, dsr};
    if (trial >= {1'b0, dsr}) return {diff[W-1:0], dq[DW-2:0], 1'b1};
    return {trial[W-1:0], dq[DW-2:0], 1'b0};
  endfunction

  always_comb step_res = div_step(rem_q, dq_q, dsr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      dq_q   <= '0;
      dsr_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (load) begin
      rem_q  <= '0;
      dq_q   <= dvd_mag;
      dsr_q  <= dsr_mag;
      cnt_q  <= CW'(DW);
      done_q <= 1'b0;
    end else if (kill) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (cnt_q != '0) begin
      {rem_q, dq_q} <= step_res;
      cnt_q  <= cnt_q - CW'(1);
      done_q <= (cnt_q == CW'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign q_mag  = dq_q;
  assign r_mag  = rem_q;
  assign done   = done_q;
  assign active = (cnt_q != '0);

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (dsr_q != '0) && (rem_q < dsr_q)); // R4
endmodule

// File: rtl/sdiv_result_fmt.sv
module sdiv_result_fmt #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] q_mag,
  input  logic [W-1:0]   r_mag,
  input  logic           neg_q,
  input  logic           neg_r,
  input  logic           wide,
  output logic [W-1:0]   q_out,
  output logic [W-1:0]   r_out
);
  localparam int DW = 2 * W;
  localparam logic [DW-1:0] NEG_MAG = {{W{1'b0}}, 1'b1, {(W-1){1'b0}}};
  localparam logic [DW-1:0] POS_MAG = {{(W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic [W-1:0]  WORD_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0]  WORD_MIN = {1'b1, {(W-1){1'b0}}};

  function automatic logic [DW-1:0] signed_dw(input logic [DW-1:0] m, input logic neg);
    return neg ? (~m + DW'(1)) : m;
  endfunction

  function automatic logic [W-1:0] signed_w(input logic [W-1:0] m, input logic neg);
    return neg ? (~m + W'(1)) : m;
  endfunction

  function automatic logic fits_word(input logic [DW-1:0] m, input logic neg);
    return neg ? (m <= NEG_MAG) : (m <= POS_MAG);
  endfunction

  logic [DW-1:0] q_full;
  logic          sat;

  always_comb begin
    q_full = signed_dw(q_mag, neg_q);
    sat    = wide && !fits_word(q_mag, neg_q);
    q_out  = sat ? (neg_q ? WORD_MIN : WORD_MAX) : q_full[W-1:0];
    r_out  = signed_w(r_mag, neg_r);
  end
endmodule

// File: rtl/sdiv_mmio.sv
module sdiv_mmio
  import sdiv_pkg::*;
#(
  parameter int W = 32,
  localparam int AW = $clog2(REG_COUNT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_waddr,
  input  logic [W-1:0]  bus_wdata,
  input  logic [AW-1:0] bus_raddr,
  output logic [W-1:0]  bus_rdata,
  output logic          busy
);
  localparam int DW = 2 * W;

  logic [W-1:0]         regs_q [REG_COUNT];
  logic [REG_COUNT-1:0] reg_wen;
  start_e               start_kind;
  logic                 start_run, start_zero, start_any, commit;
  logic [DW-1:0]        op_dvd, dvd_mag, q_mag;
  logic [W-1:0]         dsr_mag, r_mag, q_out, r_out;
  logic                 core_done, core_active;
  logic                 neg_q_q, neg_r_q, wide_q;

  function automatic logic [DW-1:0] mag_dw(input logic [DW-1:0] v);
    return v[DW-1] ? (~v + DW'(1)) : v;
  endfunction

  function automatic logic [W-1:0] mag_w(input logic [W-1:0] v);
    return v[W-1] ? (~v + W'(1)) : v;
  endfunction

  sdiv_wr_decode #(.AW(AW)) u_dec (
    .we         (bus_we),
    .waddr      (bus_waddr),
    .divisor_nz (regs_q[IDX_DIVISOR] != '0),
    .reg_wen    (reg_wen),
    .start_kind (start_kind)
  );

  assign start_run  = (start_kind == START_NARROW) || (start_kind == START_WIDE);
  assign start_zero = (start_kind == START_ZERO);
  assign start_any  = start_run || start_zero;

  always_comb begin
    op_dvd  = (start_kind == START_WIDE) ? {regs_q[IDX_WIDE_HI], bus_wdata}
                                         : {{W{bus_wdata[W-1]}}, bus_wdata};
    dvd_mag = mag_dw(op_dvd);
    dsr_mag = mag_w(regs_q[IDX_DIVISOR]);
  end

  sdiv_core #(.W(W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_run),
    .kill    (start_zero),
    .dvd_mag (dvd_mag),
    .dsr_mag (dsr_mag),
    .q_mag   (q_mag),
    .r_mag   (r_mag),
    .done    (core_done),
    .active  (core_active)
  );

  sdiv_result_fmt #(.W(W)) u_fmt (
    .q_mag (q_mag),
    .r_mag (r_mag),
    .neg_q (neg_q_q),
    .neg_r (neg_r_q),
    .wide  (wide_q),
    .q_out (q_out),
    .r_out (r_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q_q <= 1'b0;
      neg_r_q <= 1'b0;
      wide_q  <= 1'b0;
    end else if (start_run) begin
      neg_q_q <= op_dvd[DW-1] ^ regs_q[IDX_DIVISOR][W-1];
      neg_r_q <= op_dvd[DW-1];
      wide_q  <= (start_kind == START_WIDE);
    end
  end

  assign commit = core_done && !start_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_COUNT; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < REG_COUNT; i++)
        if (reg_wen[i]) regs_q[i] <= bus_wdata;
      if (start_zero) begin
        regs_q[IDX_WIDE_HI] <= '0;
        regs_q[IDX_WIDE_LO] <= '0;
        regs_q[IDX_REM_MIR] <= '0;
        regs_q[IDX_QUO_MIR] <= '0;
      end else if (commit) begin
        regs_q[IDX_WIDE_HI] <= r_out;
        regs_q[IDX_REM_MIR] <= r_out;
        regs_q[IDX_QUO_MIR] <= q_out;
        if (wide_q) regs_q[IDX_WIDE_LO] <= q_out;
        else        regs_q[IDX_NARROW]  <= q_out;
      end
    end
  end

  assign busy      = core_active || core_done;
  assign bus_rdata = MAPPED_MASK[bus_raddr] ? regs_q[bus_raddr] : '0;

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_run |=> busy); // R8
  AST_ZERO_DIVISOR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_zero |=> !busy && regs_q[IDX_WIDE_HI] == '0 && regs_q[IDX_WIDE_LO] == '0
                 && regs_q[IDX_REM_MIR] == '0 && regs_q[IDX_QUO_MIR] == '0); // R5
  AST_REM_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> regs_q[IDX_WIDE_HI] == regs_q[IDX_REM_MIR]); // R2
  AST_QUOT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(start_zero) |->
      regs_q[IDX_QUO_MIR] == (wide_q ? regs_q[IDX_WIDE_LO] : regs_q[IDX_NARROW])); // R3
endmodule

// File: tb/sdiv_mmio_bench.sv
module sdiv_mmio_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 4;
  localparam int AW   = 3;
  localparam int MINV = -(1 << (DW - 1));
  localparam int MAXV = (1 << (DW - 1)) - 1;
  localparam int BUSY_LEN = 2 * DW + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_waddr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [AW-1:0] bus_raddr = '0;
  logic [DW-1:0] bus_rdata;
  logic          busy;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  logic [DW-1:0] exp_qmir = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sdiv_mmio #(.W(DW)) u_sdiv_mmio (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata), .busy(busy)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input int val);
    bus_we = 1'b1; bus_waddr = idx[AW-1:0]; bus_wdata = val[DW-1:0];
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [DW-1:0] v);
    bus_raddr = idx[AW-1:0];
    #1;
    v = bus_rdata;
  endtask

  task automatic wait_done(output int n);
    logic [DW-1:0] v;
    n = 0;
    while (busy && n < 100) begin
      n++;
      if (n == 2) begin
        rd(7, v);
        check("R8 read while busy", v, exp_qmir);
      end
      @(negedge clk);
    end
  endtask

  task automatic expect_results(input string req, input int qidx, input int q, input int r);
    logic [DW-1:0] v;
    rd(qidx, v); check(req, v, q[DW-1:0]);
    rd(7, v);    check(req, v, q[DW-1:0]);
    rd(4, v);    check("R4 remainder", v, r[DW-1:0]);
    rd(6, v);    check("R4 remainder copy", v, r[DW-1:0]);
    exp_qmir = q[DW-1:0];
  endtask

  task automatic expect_cleared(input string req);
    logic [DW-1:0] v;
    check({req, " busy low"}, {{(DW-1){1'b0}}, busy}, '0);
    for (int i = 4; i < 8; i++) begin
      rd(i, v); check(req, v, '0);
    end
    exp_qmir = '0;
  endtask

  task automatic run_narrow(input int a, input int b);
    int n;
    logic [DW-1:0] v;
    wr(0, b);
    wr(1, a);
    if (b == 0) begin
      expect_cleared("R5 narrow zero divisor");
      rd(1, v); check("R5 dividend kept", v, a[DW-1:0]);
    end else begin
      wait_done(n);
      check("R8 busy length", n[DW-1:0], BUSY_LEN[DW-1:0]);
      if (a == MINV && b == -1) expect_results("R7 min by minus one", 1, MINV, 0);
      else expect_results("R2 narrow quotient", 1, a / b, a % b);
    end
  endtask

  task automatic run_wide(input int hi, input int lo, input int b);
    int n, big, q;
    wr(0, b);
    wr(4, hi);
    wr(5, lo);
    if (b == 0) begin
      expect_cleared("R5 wide zero divisor");
    end else begin
      big = hi * (1 << DW) + lo;
      if (big >= (1 << (2 * DW - 1))) big -= (1 << (2 * DW));
      q = big / b;
      wait_done(n);
      check("R8 busy length", n[DW-1:0], BUSY_LEN[DW-1:0]);
      if (q > MAXV)      expect_results("R6 saturate high", 5, MAXV, big % b);
      else if (q < MINV) expect_results("R6 saturate low", 5, MINV, big % b);
      else               expect_results("R3 wide quotient", 5, q, big % b);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [DW-1:0] v;
    int n;
    repeat (3) @(negedge clk);
    check("R10 busy after reset", {{(DW-1){1'b0}}, busy}, '0);
    for (int i = 0; i < 8; i++) begin
      rd(i, v); check("R10 reset value", v, '0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    wr(2, 5); rd(2, v); check("R1 unmapped index 2", v, '0);
    wr(3, 9); rd(3, v); check("R1 unmapped index 3", v, '0);
    wr(6, 3); rd(6, v); check("R1 store index 6", v, 4'd3);
    wr(0, 6); rd(0, v); check("R1 store index 0", v, 4'd6);
    wr(7, 0); exp_qmir = '0;

    for (int b = MINV; b <= MAXV; b++)
      for (int a = MINV; a <= MAXV; a++)
        run_narrow(a, b);

    for (int b = MINV; b <= MAXV; b++)
      for (int hi = 0; hi < (1 << DW); hi++)
        for (int lo = 0; lo < (1 << DW); lo++)
          run_wide(hi, lo, b);

    // R9: restart while busy; the first wide result must never land
    wr(0, 3); wr(4, 0); wr(5, 7);
    repeat (3) @(negedge clk);
    wr(0, -2);
    wr(1, 5);
    wait_done(n);
    check("R9 busy length after restart", n[DW-1:0], BUSY_LEN[DW-1:0]);
    expect_results("R9 restart quotient", 1, -2, 1);
    rd(5, v); check("R9 abandoned result not written", v, 4'd7);

    // R5: zero-divisor start abandons a running divide
    wr(0, 3); wr(4, 0); wr(5, 2);
    @(negedge clk);
    wr(0, 0);
    wr(1, 6);
    expect_cleared("R5 abort by zero divisor");
    repeat (BUSY_LEN + 2) @(negedge clk);
    expect_cleared("R5 no late result");
    rd(1, v); check("R5 dividend kept after abort", v, 4'd6);

    summary();
  end
endmodule